// File: doc/BRIEF.md
# Block Transfer Repeat Sequencer

This block moves a run of bytes or 16-bit words from one memory region to another through a single request/acknowledge memory port. A pulse on `start` loads the following values, which are held for the whole transfer:
- a source pointer and a destination pointer;
- a 16-bit element count;
- three mode bits: element size, direction, and single or repeating.

Each element is handled as one step:
1. The block reads the element at the source pointer.
2. It writes the element to the destination pointer.
3. It moves both pointers by the element size.
4. It decrements the count and updates a completion flag.

In the single form the block stops after one element, whatever the count. In the repeating form it issues the next step again for as long as the count stays nonzero.

The pointers and the remaining count are visible at the ports. A surrounding engine can therefore pick up the registers after each run. The completion flag works like an overflow bit: it is set only when an element brings the count to zero.

Top module: `blkmove_seq`

## Requirements
- R1: A `start` pulse while idle loads the pointers, the count and the mode inputs. `busy` is high from the next cycle on.
- R2: Each element is first read at the source address (`mem_we`=0) and then written at the destination address (`mem_we`=1). In byte mode (`mem_word`=0) the value moved is bits 7:0 of the read data, placed in bits 7:0 of `mem_wdata`. In word mode (`mem_word`=1) all 16 bits are moved.
- R3: After each element both pointers move by the step size: 1 in byte mode, 2 in word mode. They move up when `dir_down`=0 and down when `dir_down`=1.
- R4: The count drops by exactly one per element. `v_flag` is set when the new count is zero and cleared when it is nonzero. `v_flag` changes only when an element completes.
- R5: In repeat mode (`repeat_en`=1) the block keeps issuing steps until an element leaves the count at zero.
- R6: In single mode (`repeat_en`=0) the block stops after one element, whatever count remains.
- R7: A count of zero on entry wraps to 0xFFFF after the first element. A repeating transfer started with count zero therefore continues.
- R8: `start` is ignored while `busy` is high: the transfer in flight completes with its original parameters.
- R9: `done` is high for exactly one cycle, in the first idle cycle after the last element. A `start` pulse in that same cycle begins a new transfer.
- R10: After reset the block is idle, with no memory request, `done` low, `v_flag` low, and the count and both pointers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (used only when idle) |
| word_mode | input | 1 | 1 = 16-bit elements, 0 = bytes |
| dir_down | input | 1 | 1 = pointers decrement, 0 = increment |
| repeat_en | input | 1 | 1 = repeat until count is zero, 0 = one element |
| src_in | input | AW | Initial source pointer |
| dst_in | input | AW | Initial destination pointer |
| count_in | input | CW | Initial element count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access size of the current transfer |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| v_flag | output | 1 | Set when an element brought the count to zero |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Current remaining count |

## Verification
Two functions can fall in the same cycle:
- the completion pulse of one transfer;
- the acceptance of the next `start`.

The bench provokes this by raising `start` exactly in the cycle where `done` is seen high. It judges the result from three observations:
- `done` lasted one cycle;
- `busy` returned in the following cycle;
- the second transfer left memory, pointers and count as a reference copy loop predicts.

A second pairing is a `start` that arrives while an element is in flight. It is judged by checking that the first transfer's outcome is unchanged.

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          word_mode,
  input  logic          dir_down,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] count_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          done,
  output logic          v_flag,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count
);

  localparam int BW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_UPD} state_t;

  state_t        st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          word_q, down_q, rep_q, v_q, done_q;

  logic [AW-1:0] step_w, src_nx, dst_nx;
  logic [CW-1:0] cnt_nx;
  logic          last_nx;

  assign step_w  = word_q ? AW'(2) : AW'(1);
  assign src_nx  = down_q ? src_q - step_w : src_q + step_w;
  assign dst_nx  = down_q ? dst_q - step_w : dst_q + step_w;
  assign cnt_nx  = cnt_q - CW'(1);
  assign last_nx = (cnt_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      word_q <= 1'b0;
      down_q <= 1'b0;
      rep_q  <= 1'b0;
      v_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          src_q  <= src_in;
          dst_q  <= dst_in;
          cnt_q  <= count_in;
          word_q <= word_mode;
          down_q <= dir_down;
          rep_q  <= repeat_en;
          st     <= S_RD;
        end
        S_RD: if (mem_ack) begin
          data_q <= word_q ? mem_rdata : {{(DW-BW){1'b0}}, mem_rdata[BW-1:0]};
          st     <= S_WR;
        end
        S_WR: if (mem_ack) st <= S_UPD;
        S_UPD: begin
          src_q <= src_nx;
          dst_q <= dst_nx;
          cnt_q <= cnt_nx;
          v_q   <= last_nx;
          if (rep_q && !last_nx) begin
            st <= S_RD;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_word  = word_q;
  assign mem_addr  = (st == S_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign done      = done_q;
  assign v_flag    = v_q;
  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign count     = cnt_q;

endmodule

// File: rtl/blkmove_seq_chk.sv
module blkmove_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          v_flag,
  input logic          word_q,
  input logic          down_q,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] count
);

  logic [AW-1:0] step_c;
  assign step_c = word_q ? AW'(2) : AW'(1);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r4_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && count != $past(count)) |-> count == $past(count) - CW'(1));

  a_r4_v_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && count != $past(count)) |-> v_flag == (count == '0));

  a_r3_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && src_ptr != $past(src_ptr)) |->
      src_ptr == (down_q ? $past(src_ptr) - step_c : $past(src_ptr) + step_c));

  a_r3_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && dst_ptr != $past(dst_ptr)) |->
      dst_ptr == (down_q ? $past(dst_ptr) - step_c : $past(dst_ptr) + step_c));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(word_q) && $stable(down_q));

endmodule

bind blkmove_seq blkmove_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .v_flag(v_flag), .word_q(word_q), .down_q(down_q),
  .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count)
);

// File: tb/tb_blkmove_seq.sv
module tb_blkmove_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, word_mode = 1'b0, dir_down = 1'b0, repeat_en = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, count_in = '0;
  logic        mem_req, mem_we, mem_word, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, done, v_flag;
  logic [15:0] src_ptr, dst_ptr, count;

  int tests = 0, fails = 0;
  logic [7:0] mem [0:255];
  logic [7:0] shadow [0:255];

  always #10 clk = ~clk;

  blkmove_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .dir_down(dir_down), .repeat_en(repeat_en), .src_in(src_in),
    .dst_in(dst_in), .count_in(count_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .v_flag(v_flag), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7) ^ seed;
      shadow[i] = mem[i];
    end
  endtask

  task automatic ref_run(input bit w, input bit d, input bit r,
                         input logic [15:0] s, input logic [15:0] t, input logic [15:0] c,
                         output logic [15:0] so, output logic [15:0] to,
                         output logic [15:0] co, output bit vo);
    logic [15:0] st;
    st = w ? 16'd2 : 16'd1;
    vo = 1'b0;
    do begin
      shadow[t[7:0]] = shadow[s[7:0]];
      if (w) shadow[8'(t[7:0] + 8'd1)] = shadow[8'(s[7:0] + 8'd1)];
      s = d ? s - st : s + st;
      t = d ? t - st : t + st;
      c = c - 16'd1;
      vo = (c == 16'd0);
    end while (r && c != 16'd0);
    so = s; to = t; co = c;
  endtask

  task automatic launch(input bit w, input bit d, input bit r,
                        input logic [15:0] s, input logic [15:0] t, input logic [15:0] c);
    word_mode = w; dir_down = d; repeat_en = r;
    src_in = s; dst_in = t; count_in = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done seen"}, 32'(done), 1);
  endtask

  task automatic compare(input string tag, input logic [15:0] so, input logic [15:0] to,
                         input logic [15:0] co, input bit vo);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, {tag, " memory image"}, 32'(bad), 0);
    chk(src_ptr == so, {tag, " src_ptr"}, 32'(src_ptr), 32'(so));
    chk(dst_ptr == to, {tag, " dst_ptr"}, 32'(dst_ptr), 32'(to));
    chk(count == co, {tag, " count"}, 32'(count), 32'(co));
    chk(v_flag == vo, {tag, " v_flag"}, 32'(v_flag), 32'(vo));
  endtask

  task automatic run_xfer(input string tag, input bit w, input bit d, input bit r,
                          input logic [15:0] s, input logic [15:0] t, input logic [15:0] c);
    logic [15:0] so, to, co;
    bit vo;
    fill(8'(s ^ t));
    ref_run(w, d, r, s, t, c, so, to, co, vo);
    launch(w, d, r, s, t, c);
    chk(busy, {tag, " R1 busy after start"}, 32'(busy), 1);
    wait_done(tag);
    chk(!busy, {tag, " R9 idle with done"}, 32'(busy), 0);
    compare(tag, so, to, co, vo);
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, 32'(done), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req, "R10 idle after reset", {30'd0, busy, mem_req}, 0);
    chk(!done && !v_flag, "R10 done/v low", {30'd0, done, v_flag}, 0);
    chk(count == 0 && src_ptr == 0 && dst_ptr == 0, "R10 regs zero", 32'(count), 0);
  endtask

  task automatic t_ignore_start;
    logic [15:0] so, to, co;
    bit vo;
    fill(8'h3C);
    ref_run(1'b0, 1'b0, 1'b1, 16'h0010, 16'h0080, 16'd4, so, to, co, vo);
    launch(1'b0, 1'b0, 1'b1, 16'h0010, 16'h0080, 16'd4);
    repeat (3) @(negedge clk);
    launch(1'b1, 1'b1, 1'b0, 16'h00F0, 16'h0040, 16'd9);
    wait_done("R8 start while busy");
    compare("R8 start while busy", so, to, co, vo);
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    logic [15:0] so, to, co;
    bit vo;
    fill(8'h5A);
    ref_run(1'b0, 1'b0, 1'b1, 16'h0020, 16'h0060, 16'd3, so, to, co, vo);
    ref_run(1'b1, 1'b0, 1'b1, 16'h00A0, 16'h00C0, 16'd2, so, to, co, vo);
    launch(1'b0, 1'b0, 1'b1, 16'h0020, 16'h0060, 16'd3);
    wait_done("R9 first of pair");
    launch(1'b1, 1'b0, 1'b1, 16'h00A0, 16'h00C0, 16'd2);
    chk(busy, "R9 start in done cycle accepted", 32'(busy), 1);
    chk(!done, "R9 done dropped", 32'(done), 0);
    wait_done("R9 second of pair");
    compare("R9 second of pair", so, to, co, vo);
    @(negedge clk);
  endtask

  task automatic t_wrap_repeat;
    int n = 0;
    fill(8'h11);
    launch(1'b0, 1'b0, 1'b1, 16'h0000, 16'h0080, 16'd0);
    while (count != 16'hFFFD && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(count == 16'hFFFD, "R7 count wrapped from zero", 32'(count), 32'hFFFD);
    chk(busy, "R7 repeat continues after wrap", 32'(busy), 1);
    chk(!v_flag, "R7 v clear while nonzero", 32'(v_flag), 0);
    chk(mem[8'h82] == shadow[8'h02], "R7 third element moved", 32'(mem[8'h82]), 32'(shadow[8'h02]));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R10 reset stops transfer", 32'(busy), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_xfer("R2 R5 byte up repeat", 1'b0, 1'b0, 1'b1, 16'h0010, 16'h0040, 16'd6);
    run_xfer("R3 word down repeat", 1'b1, 1'b1, 1'b1, 16'h0050, 16'h00B0, 16'd3);
    run_xfer("R3 byte down repeat", 1'b0, 1'b1, 1'b1, 16'h0030, 16'h0090, 16'd5);
    run_xfer("R6 word up single", 1'b1, 1'b0, 1'b0, 16'h0004, 16'h0070, 16'd5);
    run_xfer("R4 single reaches zero", 1'b0, 1'b0, 1'b0, 16'h0008, 16'h0028, 16'd1);
    run_xfer("R7 single from zero", 1'b0, 1'b0, 1'b0, 16'h000C, 16'h002C, 16'd0);
    run_xfer("R2 overlapping byte copy", 1'b0, 1'b0, 1'b1, 16'h0040, 16'h0041, 16'd4);
    t_ignore_start();
    t_back_to_back();
    t_wrap_repeat();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule